// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This unit takes two IEEE-754 operands and either compares them or picks the smaller or larger one. A format input selects single precision (the low 32 bits of each operand bus) or double precision (all 64 bits). The opcode selects one of five operations. The three compares (equal, greater-than, greater-or-equal) produce a one-bit predicate. Minimum and maximum produce a data word as wide as the chosen format.

NaN inputs follow fixed rules. Compares are quiet: they return false and raise no flag. If exactly one operand of min/max is a NaN, the unit returns the other operand. If both are NaN, it returns an all-ones word. In double precision only, min/max with any NaN operand raises the invalid flag.

The caller supplies the current user status word. The unit returns that word with its own flags ORed in, so a flag already set stays set. Each accepted request produces its results one clock later, together with a valid strobe.

Top module: `fpcm_unit`

## Requirements
- R1: A request sampled with `in_valid` high gives `out_valid` high exactly one clock later. Clocks with `in_valid` low give `out_valid` low one clock later.
- R2: With opcode 0 (equal), 1 (greater-than) or 2 (greater-or-equal) and no NaN operand, `out_pred` is the ordering of a against b. Ordering uses sign and magnitude, and infinities are the largest magnitudes. `out_result` is zero for these opcodes.
- R3: Every compare opcode gives `out_pred` = 0 when either operand is a NaN. A NaN has an all-ones exponent and a nonzero fraction, and quiet and signalling NaNs are treated alike.
- R4: Compare opcodes never add a flag: `out_stat` equals the `in_stat` of that request, including when an operand is a NaN.
- R5: In single precision (`in_fmt` = 0), opcode 3 (min) or 4 (max) with one NaN returns the other operand. With two NaNs it returns 0xFFFFFFFF. The upper 32 result bits are zero, and no flag is added.
- R6: In double precision (`in_fmt` = 1), min or max with one NaN returns the other operand. With two NaNs it returns 0xFFFFFFFFFFFFFFFF.
- R7: In double precision, min or max with at least one NaN operand sets status bit 1 (invalid) in `out_stat`.
- R8: Positive zero and negative zero compare as equal. When the operands are zeros of opposite sign, min returns negative zero and max returns positive zero.
- R9: Min and max of two non-NaN operands return the smaller and the larger operand respectively. `out_pred` is zero for these opcodes.
- R10: `out_stat` is always `in_stat` ORed with the unit's flags. The unit never clears a bit, and it never sets bits 2 (divide-by-zero), 3 (overflow), 4 (underflow) or 5 (inexact).
- R11: During and right after reset, `out_valid`, `out_pred`, `out_result` and `out_stat` are all zero.
- R12: Opcodes 5 to 7 are reserved. They give `out_pred` = 0 and `out_result` = 0, and pass `in_stat` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 1 | 0 = single precision (low 32 bits), 1 = double precision |
| in_op | input | 3 | 0 eq, 1 gt, 2 ge, 3 min, 4 max, 5-7 reserved |
| in_a | input | 64 | Operand a |
| in_b | input | 64 | Operand b |
| in_stat | input | 8 | Current user status word |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_pred | output | 1 | Compare predicate |
| out_result | output | 64 | Min/max data result |
| out_stat | output | 8 | Status word with the unit's flags merged in |

## Verification
Every result of a request (predicate, data word and merged status) is registered together, so all of them become visible at the first rising edge after the edge that samples the request. The bench drives each request on a falling edge. At the same moment it queues the result expected from the requirements. On each falling edge where `out_valid` is high, the bench pops one queued item and compares it. Each comparison therefore lands exactly one clock after its stimulus, and a result that arrives early, late or unrequested shows up as a mismatch or as an empty queue.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;
  localparam logic [2:0] OP_EQ  = 3'd0;
  localparam logic [2:0] OP_GT  = 3'd1;
  localparam logic [2:0] OP_GE  = 3'd2;
  localparam logic [2:0] OP_MIN = 3'd3;
  localparam logic [2:0] OP_MAX = 3'd4;

  localparam int FLAG_INVALID = 1;
  localparam int FLAG_DIVZ    = 2;
  localparam int FLAG_OVF     = 3;
  localparam int FLAG_UNF     = 4;
  localparam int FLAG_INEXACT = 5;

  typedef struct packed {
    logic nan;
    logic zero;
    logic sign;
  } fpcm_class_t;
endpackage

// File: rtl/fpcm_classify.sv
module fpcm_classify
  import fpcm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fpcm_class_t           cls
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = val[W-2:FRAC_W];
  assign frac_f = val[FRAC_W-1:0];

  always_comb begin
    cls.sign = val[W-1];
    cls.nan  = (&exp_f) && (|frac_f);
    cls.zero = ~|val[W-2:0];
  end
endmodule

// File: rtl/fpcm_lane.sv
module fpcm_lane
  import fpcm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output logic                  nan_a,
  output logic                  nan_b,
  output logic                  a_lt_b,
  output logic                  a_eq_b,
  output logic [EXP_W+FRAC_W:0] min_v,
  output logic [EXP_W+FRAC_W:0] max_v
);
  localparam int W = EXP_W + FRAC_W + 1;

  fpcm_class_t ca, cb;
  logic [W-2:0] mag_a, mag_b;
  logic both_zero;

  fpcm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.val(a), .cls(ca));
  fpcm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.val(b), .cls(cb));

  assign mag_a     = a[W-2:0];
  assign mag_b     = b[W-2:0];
  assign both_zero = ca.zero && cb.zero;
  assign nan_a     = ca.nan;
  assign nan_b     = cb.nan;

  always_comb begin
    a_eq_b = both_zero || (a == b);
    if (both_zero)             a_lt_b = 1'b0;
    else if (ca.sign != cb.sign) a_lt_b = ca.sign;
    else if (!ca.sign)         a_lt_b = mag_a < mag_b;
    else                       a_lt_b = mag_a > mag_b;
  end

  always_comb begin
    if (ca.nan && cb.nan) begin
      min_v = '1;
      max_v = '1;
    end else if (ca.nan) begin
      min_v = b;
      max_v = b;
    end else if (cb.nan) begin
      min_v = a;
      max_v = a;
    end else if (both_zero) begin
      min_v = ca.sign ? a : b;
      max_v = ca.sign ? b : a;
    end else begin
      min_v = a_lt_b ? a : b;
      max_v = a_lt_b ? b : a;
    end
  end
endmodule

// File: rtl/fpcm_unit.sv
module fpcm_unit
  import fpcm_pkg::*;
#(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  parameter int STAT_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic                                 in_fmt,
  input  logic [2:0]                           in_op,
  input  logic [DP_EXP+DP_FRAC:0]              in_a,
  input  logic [DP_EXP+DP_FRAC:0]              in_b,
  input  logic [STAT_W-1:0]                    in_stat,
  output logic                                 out_valid,
  output logic                                 out_pred,
  output logic [DP_EXP+DP_FRAC:0]              out_result,
  output logic [STAT_W-1:0]                    out_stat
);
  localparam int SP_W  = SP_EXP + SP_FRAC + 1;
  localparam int DP_W  = DP_EXP + DP_FRAC + 1;
  localparam int PAD_W = DP_W - SP_W;

  logic            sp_nan_a, sp_nan_b, sp_lt, sp_eq;
  logic [SP_W-1:0] sp_min, sp_max;
  logic            dp_nan_a, dp_nan_b, dp_lt, dp_eq;
  logic [DP_W-1:0] dp_min, dp_max;

  fpcm_lane #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
    .a(in_a[SP_W-1:0]), .b(in_b[SP_W-1:0]),
    .nan_a(sp_nan_a), .nan_b(sp_nan_b), .a_lt_b(sp_lt), .a_eq_b(sp_eq),
    .min_v(sp_min), .max_v(sp_max)
  );

  fpcm_lane #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
    .a(in_a), .b(in_b),
    .nan_a(dp_nan_a), .nan_b(dp_nan_b), .a_lt_b(dp_lt), .a_eq_b(dp_eq),
    .min_v(dp_min), .max_v(dp_max)
  );

  logic            any_nan, lt, eq;
  logic [DP_W-1:0] min_w, max_w;
  logic            pred_n;
  logic [DP_W-1:0] res_n;
  logic [STAT_W-1:0] flag_n;

  always_comb begin
    if (in_fmt) begin
      any_nan = dp_nan_a || dp_nan_b;
      lt      = dp_lt;
      eq      = dp_eq;
      min_w   = dp_min;
      max_w   = dp_max;
    end else begin
      any_nan = sp_nan_a || sp_nan_b;
      lt      = sp_lt;
      eq      = sp_eq;
      min_w   = {{PAD_W{1'b0}}, sp_min};
      max_w   = {{PAD_W{1'b0}}, sp_max};
    end
  end

  always_comb begin
    pred_n = 1'b0;
    res_n  = '0;
    flag_n = '0;
    case (in_op)
      OP_EQ: pred_n = !any_nan && eq;
      OP_GT: pred_n = !any_nan && !lt && !eq;
      OP_GE: pred_n = !any_nan && !lt;
      OP_MIN, OP_MAX: begin
        res_n = (in_op == OP_MIN) ? min_w : max_w;
        flag_n[FLAG_INVALID] = in_fmt && any_nan;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_pred   <= 1'b0;
      out_result <= '0;
      out_stat   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pred   <= pred_n;
        out_result <= res_n;
        out_stat   <= in_stat | flag_n;
      end
    end
  end
endmodule

// File: rtl/fpcm_unit_chk.sv
module fpcm_unit_chk #(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  parameter int STAT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_fmt,
  input logic [2:0]              in_op,
  input logic [DP_EXP+DP_FRAC:0] in_a,
  input logic [DP_EXP+DP_FRAC:0] in_b,
  input logic [STAT_W-1:0]       in_stat,
  input logic                    out_valid,
  input logic                    out_pred,
  input logic [DP_EXP+DP_FRAC:0] out_result,
  input logic [STAT_W-1:0]       out_stat
);
  localparam int SP_W = SP_EXP + SP_FRAC + 1;
  localparam int DP_W = DP_EXP + DP_FRAC + 1;

  logic sa_nan, sb_nan, da_nan, db_nan, nan_sel, is_cmp, is_mm;
  assign sa_nan  = (&in_a[SP_W-2:SP_FRAC]) && (|in_a[SP_FRAC-1:0]);
  assign sb_nan  = (&in_b[SP_W-2:SP_FRAC]) && (|in_b[SP_FRAC-1:0]);
  assign da_nan  = (&in_a[DP_W-2:DP_FRAC]) && (|in_a[DP_FRAC-1:0]);
  assign db_nan  = (&in_b[DP_W-2:DP_FRAC]) && (|in_b[DP_FRAC-1:0]);
  assign nan_sel = in_fmt ? (da_nan || db_nan) : (sa_nan || sb_nan);
  assign is_cmp  = in_op <= 3'd2;
  assign is_mm   = (in_op == 3'd3) || (in_op == 3'd4);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_cmp_nan_false: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp && nan_sel) |=> !out_pred);
  a_r4_cmp_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> (out_stat == $past(in_stat)));
  a_r5_sp_both_nan: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_fmt && is_mm && sa_nan && sb_nan)
      |=> (out_result == {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}}));
  a_r7_dp_invalid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_fmt && is_mm && (da_nan || db_nan)) |=> out_stat[1]);
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_stat & $past(in_stat)) == $past(in_stat)));
  a_r10_other_flags: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_stat[5:2] == $past(in_stat[5:2])));
endmodule

bind fpcm_unit fpcm_unit_chk #(
  .SP_EXP(SP_EXP), .SP_FRAC(SP_FRAC), .DP_EXP(DP_EXP), .DP_FRAC(DP_FRAC), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/fpcm_unit_test.sv
`timescale 1ns/1ps
module fpcm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_fmt = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [7:0]  in_stat = '0;
  logic        out_valid, out_pred;
  logic [63:0] out_result;
  logic [7:0]  out_stat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic        pred;
    logic [63:0] res;
    logic [7:0]  stat;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  fpcm_unit uut (.*);

  localparam logic [31:0] S_NAN = 32'h7fc00000, S_SNAN = 32'h7f800001, S_ONE = 32'h3f800000,
                          S_TWO = 32'h40000000, S_MONE = 32'hbf800000, S_MTWO = 32'hc0000000,
                          S_INF = 32'h7f800000, S_MINF = 32'hff800000, S_PZ = 32'h0, S_NZ = 32'h80000000;
  localparam logic [63:0] D_NAN = 64'h7ff8000000000000, D_ONE = 64'h3ff0000000000000,
                          D_TWO = 64'h4000000000000000, D_MONE = 64'hbff0000000000000,
                          D_MTWO = 64'hc000000000000000, D_NZ = 64'h8000000000000000;

  function automatic item_t model(string tag, logic fmt, logic [2:0] op,
                                  logic [63:0] a, logic [63:0] b, logic [7:0] st);
    item_t it;
    logic [63:0] wa, wb, ones;
    logic sa, sb2, na, nb;
    longint ka, kb;
    logic [62:0] ma, mb;
    wa   = fmt ? a : {32'b0, a[31:0]};
    wb   = fmt ? b : {32'b0, b[31:0]};
    ones = fmt ? '1 : 64'h00000000ffffffff;
    if (fmt) begin
      sa = a[63]; sb2 = b[63]; ma = a[62:0]; mb = b[62:0];
      na = (a[62:52] == 11'h7ff) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7ff) && (b[51:0] != 0);
    end else begin
      sa = a[31]; sb2 = b[31]; ma = {32'b0, a[30:0]}; mb = {32'b0, b[30:0]};
      na = (a[30:23] == 8'hff) && (a[22:0] != 0);
      nb = (b[30:23] == 8'hff) && (b[22:0] != 0);
    end
    ka = sa ? -longint'({1'b0, ma}) : longint'({1'b0, ma});
    kb = sb2 ? -longint'({1'b0, mb}) : longint'({1'b0, mb});
    it.tag = tag; it.pred = 1'b0; it.res = '0; it.stat = st;
    case (op)
      3'd0: it.pred = !na && !nb && (ka == kb);
      3'd1: it.pred = !na && !nb && (ka > kb);
      3'd2: it.pred = !na && !nb && (ka >= kb);
      3'd3, 3'd4: begin
        if (na && nb) it.res = ones;
        else if (na) it.res = wb;
        else if (nb) it.res = wa;
        else if (ka == kb && ka == 0) it.res = ((op == 3'd3) == sa) ? wa : wb;
        else if (ka == kb) it.res = wa;
        else it.res = ((ka < kb) == (op == 3'd3)) ? wa : wb;
        if (fmt && (na || nb)) it.stat = st | 8'h02;
      end
      default: ;
    endcase
    return it;
  endfunction

  task automatic drive(string tag, logic fmt, logic [2:0] op,
                       logic [63:0] a, logic [63:0] b, logic [7:0] st);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = fmt; in_op = op; in_a = a; in_b = b; in_stat = st;
    sb.push_back(model(tag, fmt, op, a, b, st));
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      item_t e;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R1: unexpected out_valid, actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        if (out_pred !== e.pred || out_result !== e.res || out_stat !== e.stat) begin
          bad++;
          $display("FAIL %s: actual pred=%0b res=%h stat=%h expected pred=%0b res=%h stat=%h",
                   e.tag, out_pred, out_result, out_stat, e.pred, e.res, e.stat);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; in_a = {32'b0, S_ONE}; in_b = {32'b0, S_ONE};
    repeat (3) @(negedge clk);
    // R11: outputs cleared by reset even with a request held on the inputs
    total++;
    if (out_valid !== 0 || out_pred !== 0 || out_result !== 0 || out_stat !== 0) begin
      bad++;
      $display("FAIL R11: actual v=%0b p=%0b r=%h s=%h expected all zero",
               out_valid, out_pred, out_result, out_stat);
    end
    in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 0 || out_stat !== 0) begin
      bad++;
      $display("FAIL R11: actual v=%0b s=%h expected 0 0 after reset", out_valid, out_stat);
    end

    // R3 / R4: quiet compares with NaN
    drive("R3", 0, 3'd0, {32'b0, S_NAN}, {32'b0, S_ONE}, 8'h00);
    drive("R3", 0, 3'd1, {32'b0, S_NAN}, {32'b0, S_ONE}, 8'h00);
    drive("R3", 0, 3'd2, {32'b0, S_ONE}, {32'b0, S_SNAN}, 8'h00);
    drive("R3", 1, 3'd0, D_NAN, D_ONE, 8'h00);
    drive("R3", 1, 3'd1, D_NAN, D_ONE, 8'h00);
    drive("R4", 1, 3'd2, D_NAN, D_NAN, 8'h00);
    drive("R4", 0, 3'd0, {32'b0, S_NAN}, {32'b0, S_NAN}, 8'h3c);
    // R2: ordering
    drive("R2", 0, 3'd0, {32'b0, S_ONE}, {32'b0, S_ONE}, 8'h00);
    drive("R2", 0, 3'd1, {32'b0, S_TWO}, {32'b0, S_ONE}, 8'h00);
    drive("R2", 0, 3'd1, {32'b0, S_ONE}, {32'b0, S_TWO}, 8'h00);
    drive("R2", 0, 3'd2, {32'b0, S_ONE}, {32'b0, S_ONE}, 8'h00);
    drive("R2", 0, 3'd1, {32'b0, S_INF}, {32'b0, S_TWO}, 8'h00);
    drive("R2", 0, 3'd1, {32'b0, S_MINF}, {32'b0, S_MONE}, 8'h00);
    drive("R2", 0, 3'd1, {32'b0, S_MONE}, {32'b0, S_MTWO}, 8'h00);
    drive("R2", 1, 3'd1, D_TWO, D_MONE, 8'h00);
    drive("R2", 1, 3'd2, D_MTWO, D_MONE, 8'h00);
    // R8: signed zeros
    drive("R8", 0, 3'd0, {32'b0, S_PZ}, {32'b0, S_NZ}, 8'h00);
    drive("R8", 0, 3'd3, {32'b0, S_PZ}, {32'b0, S_NZ}, 8'h00);
    drive("R8", 0, 3'd4, {32'b0, S_NZ}, {32'b0, S_PZ}, 8'h00);
    drive("R8", 1, 3'd3, 64'h0, D_NZ, 8'h00);
    // R5: single-precision NaN min/max
    drive("R5", 0, 3'd3, {32'b0, S_NAN}, {32'b0, S_ONE}, 8'h00);
    drive("R5", 0, 3'd4, {32'b0, S_ONE}, {32'b0, S_NAN}, 8'h00);
    drive("R5", 0, 3'd3, {32'b0, S_NAN}, {32'b0, S_SNAN}, 8'h00);
    drive("R5", 0, 3'd4, {32'b0, S_NAN}, {32'b0, S_NAN}, 8'h00);
    // R6 / R7: double-precision NaN min/max
    drive("R6", 1, 3'd3, D_NAN, D_ONE, 8'h00);
    drive("R6", 1, 3'd4, D_ONE, D_NAN, 8'h00);
    drive("R6", 1, 3'd3, D_NAN, D_NAN, 8'h00);
    drive("R7", 1, 3'd4, D_NAN, D_NAN, 8'h20);
    // R9: ordinary min/max
    drive("R9", 0, 3'd3, {32'b0, S_TWO}, {32'b0, S_ONE}, 8'h00);
    drive("R9", 0, 3'd4, {32'b0, S_MONE}, {32'b0, S_TWO}, 8'h00);
    drive("R9", 1, 3'd3, D_MONE, D_MTWO, 8'h00);
    drive("R9", 1, 3'd4, D_MONE, D_MTWO, 8'h00);
    // R10: sticky merge never clears bits
    drive("R10", 1, 3'd3, D_NAN, D_ONE, 8'hfc);
    drive("R10", 0, 3'd1, {32'b0, S_TWO}, {32'b0, S_ONE}, 8'hff);
    // R12: reserved opcodes
    drive("R12", 0, 3'd5, {32'b0, S_TWO}, {32'b0, S_ONE}, 8'h11);
    drive("R12", 1, 3'd7, D_NAN, D_NAN, 8'h00);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: every request answered, nothing more
    total++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual pending=%0d valid=%0b expected 0 0", sb.size(), out_valid);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule